// File: doc/BRIEF.md
# Latched 4-to-16 Line Decoder

This block turns a 4-bit select code into a one-of-sixteen output. The code passes through an input latch first. The latch is modelled as a register that loads on every system clock edge while the strobe input is high. When the strobe is low, the register keeps the last code it loaded, and later changes on the code input have no effect on the outputs.

The decoded outputs are built combinationally from the held code and the inhibit input. Inhibit therefore blanks all sixteen lines in the same cycle it is raised. It does not touch the held code, so the previously selected line comes back as soon as inhibit is lowered. A compile-time parameter picks the output polarity: either the selected line is high, or the selected line is low.

Top module: `sel_latch_decoder`

## Requirements
- R1: The code is read as code_i[3] the most significant bit down to code_i[0] the least significant. Held code value n selects line_o[n], for n from 0 to 15.
- R2: When strobe_i is 1 at a rising clock edge, the held code takes the value of code_i at that edge. line_o reflects the new code from that edge onward.
- R3: When strobe_i is 0 at a rising clock edge, the held code does not change, whatever code_i does.
- R4: While inhibit_i is 1, all sixteen lines are at the inactive level, in the same cycle and without waiting for a clock edge.
- R5: inhibit_i never alters the held code. Once inhibit_i returns to 0, the line selected by the held code is active again at once, with no new strobe.
- R6: With ACTIVE_HIGH=1, the selected line is 1 and the other fifteen are 0, and the inhibited state is all 0. With ACTIVE_HIGH=0, every output is the bitwise complement of the ACTIVE_HIGH=1 output, so the inhibited state is all 1.
- R7: A synchronous reset (rst=1 at a rising edge) clears the held code to 0. If inhibit_i is 0 after reset, only line_o[0] is active.
- R8: Reset takes priority over the strobe. With rst and strobe_i both 1 at an edge, the held code becomes 0.
- R9: When inhibit_i is 0, exactly one of the sixteen lines is at the active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the latch register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the held code |
| strobe_i | input | 1 | Latch enable; 1 loads code_i, 0 holds |
| code_i | input | 4 | Select code, bit 3 most significant |
| inhibit_i | input | 1 | 1 forces every line to the inactive level |
| line_o | output | 16 | Decoded one-hot lines, polarity set by ACTIVE_HIGH |

## Verification
Two functions can act in the same cycle. The first is loading a new code with the strobe. The second is blanking through inhibit. The bench raises strobe_i and inhibit_i together with a fresh code, checks that every line stays inactive, and then drops both. The line for that fresh code must then appear, which shows the load went ahead underneath the blanking. Reset combined with the strobe is judged in the same way: the held code must read as 0.

// File: rtl/sld_pkg.sv
package sld_pkg;

  // Active-high view of one line: set when the line index equals the held code and the block is not blanked
  function automatic logic line_hit(input int unsigned code, input int unsigned idx,
                                    input logic blank);
    return (!blank) && (code == idx);
  endfunction

  // Map an active-high line value onto the chosen output polarity
  function automatic logic to_polarity(input logic hit, input bit active_high);
    return active_high ? hit : !hit;
  endfunction

endpackage

// File: rtl/sld_code_latch.sv
module sld_code_latch #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_q
);

  always_ff @(posedge clk) begin
    if (rst)          code_q <= '0;
    else if (load_en) code_q <= code_in;
  end

endmodule

// File: rtl/sld_onehot_decode.sv
module sld_onehot_decode #(
  parameter int CODE_W = 4,
  localparam int LINES = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code,
  input  logic              blank,
  output logic [LINES-1:0]  hot
);
  import sld_pkg::*;

  for (genvar gi = 0; gi < LINES; gi++) begin : g_line
    assign hot[gi] = line_hit(int'(code), gi, blank);
  end

endmodule

// File: rtl/sld_polarity_stage.sv
module sld_polarity_stage #(
  parameter int LINES       = 16,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic [LINES-1:0] hot,
  output logic [LINES-1:0] lines
);
  import sld_pkg::*;

  if (ACTIVE_HIGH) begin : g_high
    assign lines = hot;
  end else begin : g_low
    for (genvar gi = 0; gi < LINES; gi++) begin : g_bit
      assign lines[gi] = to_polarity(hot[gi], 1'b0);
    end
  end

endmodule

// File: rtl/sel_latch_decoder.sv
module sel_latch_decoder #(
  parameter int CODE_W      = 4,
  parameter bit ACTIVE_HIGH = 1'b1,
  localparam int LINES      = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              inhibit_i,
  output logic [LINES-1:0]  line_o
);

  // Internal events brought out as named wires for the checker
  logic [CODE_W-1:0] held_code;
  logic [LINES-1:0]  hot_lines;

  sld_code_latch #(.CODE_W(CODE_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .load_en (strobe_i),
    .code_in (code_i),
    .code_q  (held_code)
  );

  sld_onehot_decode #(.CODE_W(CODE_W)) u_decode (
    .code  (held_code),
    .blank (inhibit_i),
    .hot   (hot_lines)
  );

  sld_polarity_stage #(.LINES(LINES), .ACTIVE_HIGH(ACTIVE_HIGH)) u_pol (
    .hot   (hot_lines),
    .lines (line_o)
  );

endmodule

// File: rtl/sld_checker.sv
module sld_checker #(
  parameter int CODE_W      = 4,
  parameter bit ACTIVE_HIGH = 1'b1,
  localparam int LINES      = 1 << CODE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe_i,
  input logic [CODE_W-1:0] code_i,
  input logic              inhibit_i,
  input logic [CODE_W-1:0] held_code,
  input logic [LINES-1:0]  line_o
);

  logic [LINES-1:0] ah_view;
  assign ah_view = ACTIVE_HIGH ? line_o : ~line_o;

  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    strobe_i |=> held_code == $past(code_i));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe_i |=> $stable(held_code));

  a_r4_blank: assert property (@(posedge clk) disable iff (rst)
    inhibit_i |-> ah_view == '0);

  a_r1_select: assert property (@(posedge clk) disable iff (rst)
    !inhibit_i |-> ah_view[held_code]);

  a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
    !inhibit_i |-> $countones(ah_view) == 1);

endmodule

bind sel_latch_decoder sld_checker #(.CODE_W(CODE_W), .ACTIVE_HIGH(ACTIVE_HIGH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .strobe_i  (strobe_i),
  .code_i    (code_i),
  .inhibit_i (inhibit_i),
  .held_code (held_code),
  .line_o    (line_o)
);

// File: tb/sel_latch_decoder_tb.sv
module sel_latch_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  // {strobe, inhibit, code[3:0], expected active-high lines[15:0]}
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 4'h5, 16'h0020},  // R2 load 5
    {1'b1, 1'b0, 4'h0, 16'h0001},  // R2 load 0
    {1'b0, 1'b0, 4'h9, 16'h0001},  // R3 data moves, hold 0
    {1'b0, 1'b1, 4'h9, 16'h0000},  // R4 blank
    {1'b0, 1'b0, 4'h3, 16'h0001},  // R5 release restores 0
    {1'b1, 1'b1, 4'hA, 16'h0000},  // R4 load under blank
    {1'b0, 1'b0, 4'h7, 16'h0400},  // R5 A appears
    {1'b1, 1'b0, 4'hF, 16'h8000},  // R1 top line
    {1'b0, 1'b0, 4'h1, 16'h8000},  // R3 hold F
    {1'b1, 1'b0, 4'h8, 16'h0100},  // R1 bit 3 msb
    {1'b1, 1'b0, 4'h1, 16'h0002},  // R1 bit 0 lsb
    {1'b0, 1'b1, 4'h2, 16'h0000},  // R4 blank hold
    {1'b0, 1'b0, 4'h2, 16'h0002}   // R5 still 1
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        strobe_i;
  logic [3:0]  code_i;
  logic        inhibit_i;
  logic [15:0] line_hi, line_lo;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sel_latch_decoder #(.CODE_W(4), .ACTIVE_HIGH(1'b1)) u_dut (
    .clk(clk), .rst(rst), .strobe_i(strobe_i), .code_i(code_i),
    .inhibit_i(inhibit_i), .line_o(line_hi));

  sel_latch_decoder #(.CODE_W(4), .ACTIVE_HIGH(1'b0)) u_dut_lo (
    .clk(clk), .rst(rst), .strobe_i(strobe_i), .code_i(code_i),
    .inhibit_i(inhibit_i), .line_o(line_lo));

  // Expected active-high value restated as a shift, independent of the RTL
  function automatic logic [15:0] expect_lines(input logic [3:0] c, input logic blank);
    return blank ? 16'h0000 : (16'h0001 << c);
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    n_chk++;
    if (line_hi !== exp) begin
      n_bad++;
      $display("FAIL %s high build: got %h expected %h", req, line_hi, exp);
    end
    n_chk++;
    if (line_lo !== ~exp) begin
      n_bad++;
      $display("FAIL %s (R6) low build: got %h expected %h", req, line_lo, ~exp);
    end
  endtask

  // Drive away from the edge, let one rising edge pass, sample after it
  task automatic step(input logic s, input logic inh, input logic [3:0] c, input logic r);
    @(negedge clk);
    strobe_i = s; inhibit_i = inh; code_i = c; rst = r;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; strobe_i = 1'b0; inhibit_i = 1'b0; code_i = 4'hC;
    step(1'b0, 1'b0, 4'hC, 1'b1);
    step(1'b0, 1'b0, 4'hC, 1'b1);
    step(1'b0, 1'b0, 4'hC, 1'b0);
    check("R7 reset selects line 0", 16'h0001);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][21], VEC[i][20], VEC[i][19:16], 1'b0);
      check($sformatf("vector %0d", i), VEC[i][15:0]);
    end

    // R1 R2 R9: walk every code with strobe high
    for (int c = 0; c < 16; c++) begin
      step(1'b1, 1'b0, 4'(c), 1'b0);
      check("R1 R9 walk", expect_lines(4'(c), 1'b0));
    end

    // R3: strobe low, data changes each cycle, held code 15 persists
    for (int c = 0; c < 4; c++) begin
      step(1'b0, 1'b0, 4'(c * 3), 1'b0);
      check("R3 hold", 16'h8000);
    end

    // R4: inhibit acts within the cycle, no edge needed
    @(negedge clk);
    inhibit_i = 1'b1;
    #1;
    check("R4 same-cycle blank", 16'h0000);
    inhibit_i = 1'b0;
    #1;
    check("R5 same-cycle restore", 16'h8000);

    // R8: reset together with strobe wins
    step(1'b1, 1'b0, 4'h6, 1'b1);
    check("R8 reset over strobe", 16'h0001);
    step(1'b0, 1'b0, 4'h6, 1'b0);
    check("R7 held zero after reset", 16'h0001);

    // R7 with inhibit held: blank, then line 0 on release
    step(1'b0, 1'b1, 4'h4, 1'b1);
    check("R4 R7 blank during reset", 16'h0000);
    step(1'b0, 1'b0, 4'h4, 1'b0);
    check("R7 line 0 after release", 16'h0001);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule